// File: doc/BRIEF.md
# Multi-Rate Timestamp Counter Block

This block keeps three free-running time counters and lets software read them through a small 32-bit read port. The first is a 56-bit timestamp counter that advances on a timestamp tick enable. The second is a 32-bit counter that advances on an oscillator tick enable. The third is a 32-bit microsecond counter, driven by a tick that a programmable prescaler derives from a reference tick enable. All tick enables come in on ports. The counters never stop, and each one wraps at its own width.

The 56-bit value is split over two read words. Reading one word does not freeze the other, so a carry from the low word into the high word can fall between two reads. Software gets a coherent value by reading the high word, then the low word, then the high word again. It repeats the low and high reads until the two high reads agree.

Top module: `timebase_counters`

## Requirements
- R1: During and right after synchronous reset, the timestamp, microsecond and oscillator counters hold the values of the parameters TS_INIT, US_INIT and OSC_INIT, and the read data is zero.
- R2: The timestamp counter goes up by exactly one on each clock edge where ts_tick_en is high, and keeps its value on every other edge. The same holds for the oscillator counter with osc_tick_en.
- R3: The timestamp counter wraps from 2^56-1 to 0.
- R4: A read at byte offset 0x000 returns timestamp bits 31:0. A read at offset 0x004 returns timestamp bits 55:32 in bits 23:0, with bits 31:24 zero.
- R5: The two timestamp words are not latched together. A high-low-high read sequence that retries while the two high reads differ yields the exact live 56-bit value, even when a low-word carry falls between the reads.
- R6: The oscillator counter reads at offset 0x00C and wraps from 2^32-1 to 0.
- R7: The prescaler issues a microsecond tick on a cycle where ref_tick_en is high and its count of enabled cycles has reached us_div. The count then restarts, so with a fixed us_div there is one tick per us_div+1 enabled reference cycles. No tick is issued while ref_tick_en is low.
- R8: The microsecond counter reads at offset 0x008, goes up by one per microsecond tick, and wraps from 2^32-1 to 0.
- R9: rd_data is registered. It takes the addressed word, as it stood before the edge, on the clock edge where rd_en is high, and keeps its value while rd_en is low.
- R10: A read at any offset other than 0x000, 0x004, 0x008 or 0x00C returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| ts_tick_en | input | 1 | Advance enable for the 56-bit timestamp counter |
| osc_tick_en | input | 1 | Advance enable for the oscillator counter |
| ref_tick_en | input | 1 | Reference enable that the microsecond prescaler counts |
| us_div | input | PRE_W | Prescaler divisor minus one |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Byte offset of the word to read |
| rd_data | output | 32 | Registered read data |

## Verification
The bench builds instance u0 with its reset values placed just below carry points. The timestamp low word starts at 0xFFFFFF00, the microsecond counter at 0xFFFFFFFA and the oscillator counter at 0xFFFFFFE0. This puts the low-to-high timestamp carry and both 32-bit wraps within a few hundred cycles. A second instance u1 starts its timestamp at 2^56-4, so the full 56-bit wrap is reached after four ticks, and its reset high word 0x00FFFFFF shows that bits 31:24 stay zero. The retry sequence is started on the cycle when the bench's own tick count puts the low word at 0xFFFFFFFE, so the carry falls exactly between the two high reads.

// File: rtl/timebase_pkg.sv
package timebase_pkg;

    localparam int TS_W   = 56;
    localparam int WORD_W = 32;
    localparam int TS_HI_W = TS_W - WORD_W;

    // byte offsets of the readable words (software depends on these)
    localparam int OFF_TS_LO = 'h000;
    localparam int OFF_TS_HI = 'h004;
    localparam int OFF_US    = 'h008;
    localparam int OFF_OSC   = 'h00C;

    typedef enum logic [2:0] {
        SEL_TS_LO,
        SEL_TS_HI,
        SEL_US,
        SEL_OSC,
        SEL_NONE
    } word_sel_e;

    typedef struct packed {
        logic [TS_W-1:0]   ts;
        logic [WORD_W-1:0] us;
        logic [WORD_W-1:0] osc;
    } count_set_t;

    // upper part of the timestamp, zero padded to a full word
    function automatic logic [WORD_W-1:0] ts_upper_word(input logic [TS_W-1:0] v);
        return {{(WORD_W - TS_HI_W){1'b0}}, v[TS_W-1:WORD_W]};
    endfunction

    function automatic logic [WORD_W-1:0] ts_lower_word(input logic [TS_W-1:0] v);
        return v[WORD_W-1:0];
    endfunction

endpackage

// File: rtl/tb_free_counter.sv
module tb_free_counter #(
    parameter int           W         = 32,
    parameter logic [W-1:0] RESET_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= RESET_VAL;
        end else if (en) begin
            q <= q + W'(1);
        end
    end

endmodule

// File: rtl/tb_us_prescaler.sv
module tb_us_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_en,
    input  logic [PRE_W-1:0] div,
    output logic             tick
);

    logic [PRE_W-1:0] cnt;
    logic             reached;

    // >= so that lowering div while counting still yields a tick
    assign reached = (cnt >= div);
    assign tick    = ref_en && reached;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (ref_en) begin
            if (reached) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + PRE_W'(1);
            end
        end
    end

endmodule

// File: rtl/tb_read_mux.sv
module tb_read_mux
    import timebase_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  count_set_t        counts,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);

    word_sel_e         sel;
    logic [WORD_W-1:0] word;

    always_comb begin
        if (rd_addr == ADDR_W'(OFF_TS_LO)) begin
            sel = SEL_TS_LO;
        end else if (rd_addr == ADDR_W'(OFF_TS_HI)) begin
            sel = SEL_TS_HI;
        end else if (rd_addr == ADDR_W'(OFF_US)) begin
            sel = SEL_US;
        end else if (rd_addr == ADDR_W'(OFF_OSC)) begin
            sel = SEL_OSC;
        end else begin
            sel = SEL_NONE;
        end
    end

    always_comb begin
        case (sel)
            SEL_TS_LO: word = ts_lower_word(counts.ts);
            SEL_TS_HI: word = ts_upper_word(counts.ts);
            SEL_US:    word = counts.us;
            SEL_OSC:   word = counts.osc;
            default:   word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= word;
        end
    end

endmodule

// File: rtl/timebase_counters.sv
module timebase_counters
    import timebase_pkg::*;
#(
    parameter int                ADDR_W   = 12,
    parameter int                PRE_W    = 8,
    parameter logic [TS_W-1:0]   TS_INIT  = '0,
    parameter logic [WORD_W-1:0] US_INIT  = '0,
    parameter logic [WORD_W-1:0] OSC_INIT = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ts_tick_en,
    input  logic              osc_tick_en,
    input  logic              ref_tick_en,
    input  logic [PRE_W-1:0]  us_div,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data
);

    logic [TS_W-1:0]   ts_q;
    logic [WORD_W-1:0] us_q;
    logic [WORD_W-1:0] osc_q;
    logic              us_tick;
    count_set_t        counts;

    tb_free_counter #(.W(TS_W), .RESET_VAL(TS_INIT)) u_ts (
        .clk (clk),
        .rst (rst),
        .en  (ts_tick_en),
        .q   (ts_q)
    );

    tb_free_counter #(.W(WORD_W), .RESET_VAL(OSC_INIT)) u_osc (
        .clk (clk),
        .rst (rst),
        .en  (osc_tick_en),
        .q   (osc_q)
    );

    tb_us_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .ref_en (ref_tick_en),
        .div    (us_div),
        .tick   (us_tick)
    );

    tb_free_counter #(.W(WORD_W), .RESET_VAL(US_INIT)) u_us (
        .clk (clk),
        .rst (rst),
        .en  (us_tick),
        .q   (us_q)
    );

    assign counts = '{ts: ts_q, us: us_q, osc: osc_q};

    tb_read_mux #(.ADDR_W(ADDR_W)) u_rd (
        .clk     (clk),
        .rst     (rst),
        .counts  (counts),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/timebase_counters_chk.sv
module timebase_counters_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              ts_tick_en,
    input logic              osc_tick_en,
    input logic              ref_tick_en,
    input logic              us_tick,
    input logic [55:0]       ts_q,
    input logic [31:0]       us_q,
    input logic [31:0]       osc_q,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [31:0]       rd_data
);

    logic decoded;
    assign decoded = (rd_addr == ADDR_W'('h000)) || (rd_addr == ADDR_W'('h004)) ||
                     (rd_addr == ADDR_W'('h008)) || (rd_addr == ADDR_W'('h00C));

    p_ts_step_r2: assert property (@(posedge clk) disable iff (rst)
        ts_tick_en |=> ts_q == $past(ts_q) + 56'd1);

    p_ts_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !ts_tick_en |=> $stable(ts_q));

    p_osc_step_r6: assert property (@(posedge clk) disable iff (rst)
        osc_tick_en |=> osc_q == $past(osc_q) + 32'd1);

    p_osc_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !osc_tick_en |=> $stable(osc_q));

    p_tick_needs_ref_r7: assert property (@(posedge clk) disable iff (rst)
        us_tick |-> ref_tick_en);

    p_us_step_r8: assert property (@(posedge clk) disable iff (rst)
        us_tick |=> us_q == $past(us_q) + 32'd1);

    p_us_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !us_tick |=> $stable(us_q));

    p_rd_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));

    p_hi_pad_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_addr == ADDR_W'('h004)) |=> rd_data[31:24] == 8'h00);

    p_undecoded_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !decoded) |=> rd_data == 32'h0);

endmodule

bind timebase_counters timebase_counters_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ts_tick_en  (ts_tick_en),
    .osc_tick_en (osc_tick_en),
    .ref_tick_en (ref_tick_en),
    .us_tick     (us_tick),
    .ts_q        (ts_q),
    .us_q        (us_q),
    .osc_q       (osc_q),
    .rd_en       (rd_en),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data)
);

// File: tb/sim_timebase_counters.sv
`timescale 1ns/1ps
module sim_timebase_counters;

    localparam logic [55:0] TS0  = 56'h00_00A5_FFFF_FF00;
    localparam logic [55:0] TS1  = 56'hFF_FFFF_FFFF_FFFC;
    localparam logic [31:0] US0  = 32'hFFFF_FFFA;
    localparam logic [31:0] OSC0 = 32'hFFFF_FFE0;
    localparam logic [11:0] A_LO  = 12'h000;
    localparam logic [11:0] A_HI  = 12'h004;
    localparam logic [11:0] A_US  = 12'h008;
    localparam logic [11:0] A_OSC = 12'h00C;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ts_tick_en = 1'b0;
    logic        osc_tick_en = 1'b0;
    logic        ref_tick_en = 1'b0;
    logic [7:0]  us_div = 8'd4;
    logic        rd_en = 1'b0;
    logic [11:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic [31:0] rd_data1;
    logic [31:0] last1;

    int checks = 0;
    int fails  = 0;
    logic [55:0] ts_ticks;

    always #4 clk = ~clk;

    timebase_counters #(.TS_INIT(TS0), .US_INIT(US0), .OSC_INIT(OSC0)) u0 (
        .clk(clk), .rst(rst), .ts_tick_en(ts_tick_en), .osc_tick_en(osc_tick_en),
        .ref_tick_en(ref_tick_en), .us_div(us_div), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    timebase_counters #(.TS_INIT(TS1)) u1 (
        .clk(clk), .rst(rst), .ts_tick_en(ts_tick_en), .osc_tick_en(osc_tick_en),
        .ref_tick_en(ref_tick_en), .us_div(us_div), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_data1)
    );

    // independent count of timestamp ticks the design has seen
    always @(posedge clk) begin
        if (rst) ts_ticks <= '0;
        else if (ts_tick_en) ts_ticks <= ts_ticks + 56'd1;
    end

    function automatic logic [55:0] ts_exp0();
        return TS0 + ts_ticks;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // called at a negedge; returns at the next negedge with the data
    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        rd_en   = 1'b1;
        rd_addr = a;
        @(negedge clk);
        d       = rd_data;
        last1   = rd_data1;
        rd_en   = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 rd_data in reset", rd_data, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        rd(A_LO, d);  chk("R1 ts low init", d, TS0[31:0]);
        rd(A_HI, d);  chk("R1/R4 ts high init", d, {8'h00, TS0[55:32]});
        chk("R4 u1 high pad zero", last1, 32'h00FF_FFFF);
        rd(A_US, d);  chk("R1 us init", d, US0);
        rd(A_OSC, d); chk("R1/R6 osc init", d, OSC0);
        rd(12'h010, d); chk("R10 offset 0x010", d, 32'h0);
        rd(12'h006, d); chk("R10 offset 0x006", d, 32'h0);
        rd(12'hFFC, d); chk("R10 offset 0xFFC", d, 32'h0);
    endtask

    task automatic t_hold();
        logic [31:0] d;
        repeat (20) @(negedge clk);
        rd(A_LO, d);  chk("R2 ts held without enable", d, TS0[31:0]);
        rd(A_OSC, d); chk("R2 osc held without enable", d, OSC0);
        repeat (3) @(negedge clk);
        chk("R9 rd_data held while idle", rd_data, OSC0);
    endtask

    task automatic t_osc();
        logic [31:0] d;
        for (int i = 0; i < 74; i++) begin
            osc_tick_en = (i % 2 == 0);
            @(negedge clk);
        end
        osc_tick_en = 1'b0;
        rd(A_OSC, d); chk("R6 osc 37 ticks with wrap", d, OSC0 + 32'd37);
    endtask

    task automatic t_us();
        logic [31:0] d;
        us_div = 8'd4;
        ref_tick_en = 1'b1;
        repeat (4) @(negedge clk);
        ref_tick_en = 1'b0;
        rd(A_US, d); chk("R7 no tick before div+1 cycles", d, US0);
        ref_tick_en = 1'b1;
        repeat (51) @(negedge clk);
        ref_tick_en = 1'b0;
        rd(A_US, d); chk("R7/R8 55 ref cycles div 5 with wrap", d, US0 + 32'd11);
        us_div = 8'd2;
        for (int i = 0; i < 30; i++) begin
            ref_tick_en = (i % 2 == 1);
            @(negedge clk);
        end
        ref_tick_en = 1'b0;
        rd(A_US, d); chk("R7/R8 15 gated ref cycles div 3", d, US0 + 32'd16);
    endtask

    task automatic t_ts_count();
        logic [31:0] d;
        ts_tick_en = 1'b1;
        repeat (100) @(negedge clk);
        ts_tick_en = 1'b0;
        rd(A_LO, d); chk("R2/R4 ts low after 100", d, ts_exp0() & 32'hFFFF_FFFF);
        chk("R3 u1 low after 56-bit wrap", last1, 32'h0000_0060);
        rd(A_HI, d); chk("R4 ts high after 100", d, {8'h00, TS0[55:32]});
        chk("R3 u1 high after 56-bit wrap", last1, 32'h0);
    endtask

    task automatic ts_coherent(output logic [55:0] v, output int retries);
        logic [31:0] hi, lo, ss;
        retries = 0;
        rd(A_HI, hi);
        forever begin
            ss = hi;
            rd(A_LO, lo);
            rd(A_HI, hi);
            if (hi == ss) break;
            retries++;
        end
        v = {hi[23:0], lo};
    endtask

    task automatic t_ts_retry();
        logic [55:0] v1, v2, exp, lo_bound;
        int r;
        ts_tick_en = 1'b1;
        while (ts_exp0()[31:0] != 32'hFFFF_FFFE) @(negedge clk);
        exp = ts_exp0() + 56'd3;
        ts_coherent(v1, r);
        chk("R5 one retry across carry", r, 1);
        chk("R5 coherent low word", v1[31:0], exp[31:0]);
        chk("R5 coherent high word", {8'h00, v1[55:32]}, {8'h00, exp[55:32]});
        repeat (7) @(negedge clk);
        lo_bound = ts_exp0();
        ts_coherent(v2, r);
        chk("R5 later read monotonic", {31'h0, v2 > v1}, 32'h1);
        chk("R5 later read within bounds",
            {31'h0, (v2 >= lo_bound) && (v2 <= ts_exp0())}, 32'h1);
        ts_tick_en = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        t_hold();
        t_osc();
        t_us();
        t_ts_count();
        t_ts_retry();
        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule